// File: doc/BRIEF.md
# Sync Pulse Input Qualifier

This block watches the external line-rate (HD) and frame-rate (VD) sync inputs of a camera timing generator. Both inputs are active low. Each is passed through a two-flop synchroniser. The block then measures the low width of every pulse and the spacing between successive falling edges, both in pixel clocks. A pulse train counts as valid only if two things hold: each pulse is at least a minimum width, and the edge-to-edge spacing sits within ±1 % of nominal. When the trains qualify, the block raises a flag that moves the camera timing onto the external reference. There is no mode register to program; the flag follows the inputs.

The line nominal comes from one of two built-in values, picked by a static standard-select input: 910 clocks for the 525-line standard and about 916 clocks for the 625-line standard. The frame nominal is one 59.94 Hz period. The block emits a one-cycle strobe for every qualified edge, together with the spacing it measured.

Entry into external mode needs four valid HD periods in a row plus a valid VD period that has not been followed by a VD fault. The block leaves external mode after eight HD faults in a row or two VD faults in a row. A fault is a spacing outside the window, a pulse that was too short, or a window that elapses without any edge.

Top module: `sync_qual`

## Requirements
- R1: After reset, ext_mode, hd_valid and vd_valid are 0 and hd_period and vd_period are 0.
- R2: On an HD falling edge, hd_valid pulses for one cycle and hd_period shows the edge-to-edge spacing in clocks. This happens only when a previous edge exists, the previous low pulse was at least HD_MIN_W clocks wide, and the spacing lies within the active window. hd_period changes only together with hd_valid.
- R3: An HD low pulse of HD_MIN_W-1 clocks makes the next spacing invalid, so no hd_valid strobe follows. A pulse of exactly HD_MIN_W clocks is accepted.
- R4: With std_sel = 0, the HD window is HD_NOM_525 ± HD_NOM_525/TOL_DIV, with both ends inclusive. Spacings outside it give no strobe.
- R5: With std_sel = 1, the HD window is HD_NOM_625 ± HD_NOM_625/TOL_DIV, with both ends inclusive. A spacing of HD_NOM_525 then gives no strobe.
- R6: VD is qualified in the same way, using VD_MIN_W and the window VD_NOM ± VD_NOM/TOL_DIV. Valid edges pulse vd_valid and load vd_period.
- R7: ext_mode (1 = external) rises only after LOCK_HD consecutive valid HD strobes, together with a valid VD strobe that no VD fault has followed. Three HD strobes are not enough, and HD alone never sets it.
- R8: In external mode, LOSS_HD consecutive HD faults clear ext_mode. LOSS_HD-1 faults followed by a valid HD strobe leave it set. An HD train that stops counts one fault per elapsed window.
- R9: In external mode, LOSS_VD consecutive VD faults clear ext_mode. A VD train that stops while HD continues counts one fault per elapsed window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| hd_n_in | input | 1 | External line sync, active low |
| vd_n_in | input | 1 | External frame sync, active low |
| std_sel | input | 1 | Static line standard select: 0 = 525-line, 1 = 625-line |
| hd_valid | output | 1 | One-cycle strobe for a qualified HD edge |
| hd_period | output | CNT_W | Last qualified HD spacing in clocks |
| vd_valid | output | 1 | One-cycle strobe for a qualified VD edge |
| vd_period | output | CNT_W | Last qualified VD spacing in clocks |
| ext_mode | output | 1 | 1 when timing follows the external sync |

## Verification
The hardest state to reach is the edge of the loss hysteresis. Here, exactly one less than the fault limit of bad HD periods must be followed by a good one, and the VD train must keep running so that it does not cause the drop itself. The bench drives HD from the main thread, one pulse at a time, with a chosen spacing and width, while a background process keeps VD running. Short spacings (below the window) then produce one fault per edge, with no timeouts mixed in, so the fault count is exact. Stopping one train while the other runs, and sampling ext_mode at times taken from the last recorded edge, covers the timeout path for both channels.

// File: rtl/sync_qual_pkg.sv
package sync_qual_pkg;

    // Selected timing reference
    typedef enum logic {
        MODE_INT = 1'b0,
        MODE_EXT = 1'b1
    } sync_mode_e;

    // Result of one measurement slot of a sync channel
    typedef struct packed {
        logic good;   // qualified edge
        logic fault;  // bad spacing, short pulse, or window elapsed
    } pulse_evt_t;

    localparam int unsigned TOL_DIV_DEFAULT = 100;

    function automatic int unsigned win_lo(int unsigned nom, int unsigned div);
        return nom - nom / div;
    endfunction

    function automatic int unsigned win_hi(int unsigned nom, int unsigned div);
        return nom + nom / div;
    endfunction

endpackage

// File: rtl/sync_qual_sync2.sv
module sync_qual_sync2 #(
    parameter int unsigned      WIDTH   = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic stage1;
        logic stage2;
        always_ff @(posedge clk) begin
            if (rst) begin
                stage1 <= RST_VAL[i];
                stage2 <= RST_VAL[i];
            end else begin
                stage1 <= din[i];
                stage2 <= stage1;
            end
        end
        assign dout[i] = stage2;
    end
endmodule

// File: rtl/sync_qual_meas.sv
module sync_qual_meas
    import sync_qual_pkg::*;
#(
    parameter int unsigned CNT_W = 20,
    parameter int unsigned MIN_W = 143
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sig_n,
    input  logic [CNT_W-1:0] lim_lo,
    input  logic [CNT_W-1:0] lim_hi,
    output pulse_evt_t       evt,
    output logic [CNT_W-1:0] period
);
    localparam logic [CNT_W-1:0] MIN_V = CNT_W'(MIN_W);
    localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);

    logic             prev;
    logic [CNT_W-1:0] per_cnt;
    logic [CNT_W-1:0] wid_cnt;
    logic             wid_ok;
    logic             have_ref;
    logic             fall;
    logic             rise;
    logic             in_win;

    assign fall   = prev & ~sig_n;
    assign rise   = ~prev & sig_n;
    assign in_win = (per_cnt >= lim_lo) && (per_cnt <= lim_hi);

    // Spacing counter, reference tracking and event generation
    always_ff @(posedge clk) begin
        if (rst) begin
            prev     <= 1'b1;
            per_cnt  <= ONE;
            have_ref <= 1'b0;
            evt      <= '0;
            period   <= '0;
        end else begin
            prev <= sig_n;
            evt  <= '0;
            if (fall) begin
                per_cnt  <= ONE;
                have_ref <= 1'b1;
                if (have_ref) begin
                    if (wid_ok && in_win) begin
                        evt.good <= 1'b1;
                        period   <= per_cnt;
                    end else begin
                        evt.fault <= 1'b1;
                    end
                end
            end else if (per_cnt >= lim_hi) begin
                // whole window gone by without an edge
                per_cnt   <= ONE;
                have_ref  <= 1'b0;
                evt.fault <= 1'b1;
            end else begin
                per_cnt <= per_cnt + ONE;
            end
        end
    end

    // Low-width counter, judged on the rising edge
    always_ff @(posedge clk) begin
        if (rst) begin
            wid_cnt <= '0;
            wid_ok  <= 1'b0;
        end else if (fall) begin
            wid_cnt <= ONE;
            wid_ok  <= 1'b0;
        end else if (rise) begin
            wid_ok <= (wid_cnt >= MIN_V);
        end else if (!sig_n && (wid_cnt < MIN_V)) begin
            wid_cnt <= wid_cnt + ONE;
        end
    end
endmodule

// File: rtl/sync_qual_lock.sv
module sync_qual_lock
    import sync_qual_pkg::*;
#(
    parameter int unsigned LOCK_HD = 4,
    parameter int unsigned LOSS_HD = 8,
    parameter int unsigned LOSS_VD = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  pulse_evt_t hd_evt,
    input  pulse_evt_t vd_evt,
    output logic       ext_mode
);
    localparam int unsigned RUN_W = $clog2(LOCK_HD + 1);
    localparam int unsigned HM_W  = $clog2(LOSS_HD + 1);
    localparam int unsigned VM_W  = $clog2(LOSS_VD + 1);
    localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(LOCK_HD);
    localparam logic [HM_W-1:0]  HM_MAX  = HM_W'(LOSS_HD);
    localparam logic [VM_W-1:0]  VM_MAX  = VM_W'(LOSS_VD);

    sync_mode_e       mode;
    logic [RUN_W-1:0] hd_run;
    logic             vd_seen;
    logic [HM_W-1:0]  hd_miss;
    logic [VM_W-1:0]  vd_miss;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode    <= MODE_INT;
            hd_run  <= '0;
            vd_seen <= 1'b0;
            hd_miss <= '0;
            vd_miss <= '0;
        end else begin
            unique case (mode)
                MODE_INT: begin
                    if (hd_evt.fault) begin
                        hd_run <= '0;
                    end else if (hd_evt.good && (hd_run != RUN_MAX)) begin
                        hd_run <= hd_run + RUN_W'(1);
                    end
                    if (vd_evt.fault) begin
                        vd_seen <= 1'b0;
                    end else if (vd_evt.good) begin
                        vd_seen <= 1'b1;
                    end
                    if ((hd_run == RUN_MAX) && vd_seen) begin
                        mode    <= MODE_EXT;
                        hd_miss <= '0;
                        vd_miss <= '0;
                    end
                end
                MODE_EXT: begin
                    if (hd_evt.good) begin
                        hd_miss <= '0;
                    end else if (hd_evt.fault && (hd_miss != HM_MAX)) begin
                        hd_miss <= hd_miss + HM_W'(1);
                    end
                    if (vd_evt.good) begin
                        vd_miss <= '0;
                    end else if (vd_evt.fault && (vd_miss != VM_MAX)) begin
                        vd_miss <= vd_miss + VM_W'(1);
                    end
                    if ((hd_miss == HM_MAX) || (vd_miss == VM_MAX)) begin
                        mode    <= MODE_INT;
                        hd_run  <= '0;
                        vd_seen <= 1'b0;
                    end
                end
                default: mode <= MODE_INT;
            endcase
        end
    end

    assign ext_mode = (mode == MODE_EXT);
endmodule

// File: rtl/sync_qual.sv
module sync_qual
    import sync_qual_pkg::*;
#(
    parameter int unsigned CNT_W      = 20,
    parameter int unsigned HD_NOM_525 = 910,
    parameter int unsigned HD_NOM_625 = 916,
    parameter int unsigned VD_NOM     = 238875,
    parameter int unsigned TOL_DIV    = TOL_DIV_DEFAULT,
    parameter int unsigned HD_MIN_W   = 143,
    parameter int unsigned VD_MIN_W   = 2864,
    parameter int unsigned LOCK_HD    = 4,
    parameter int unsigned LOSS_HD    = 8,
    parameter int unsigned LOSS_VD    = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hd_n_in,
    input  logic             vd_n_in,
    input  logic             std_sel,
    output logic             hd_valid,
    output logic [CNT_W-1:0] hd_period,
    output logic             vd_valid,
    output logic [CNT_W-1:0] vd_period,
    output logic             ext_mode
);
    localparam logic [CNT_W-1:0] HD_LO_A = CNT_W'(win_lo(HD_NOM_525, TOL_DIV));
    localparam logic [CNT_W-1:0] HD_HI_A = CNT_W'(win_hi(HD_NOM_525, TOL_DIV));
    localparam logic [CNT_W-1:0] HD_LO_B = CNT_W'(win_lo(HD_NOM_625, TOL_DIV));
    localparam logic [CNT_W-1:0] HD_HI_B = CNT_W'(win_hi(HD_NOM_625, TOL_DIV));
    localparam logic [CNT_W-1:0] VD_LO   = CNT_W'(win_lo(VD_NOM, TOL_DIV));
    localparam logic [CNT_W-1:0] VD_HI   = CNT_W'(win_hi(VD_NOM, TOL_DIV));

    logic [1:0]       raw_n;
    logic [1:0]       syn_n;
    logic [CNT_W-1:0] hd_lo;
    logic [CNT_W-1:0] hd_hi;
    pulse_evt_t       hd_evt;
    pulse_evt_t       vd_evt;

    assign raw_n = {vd_n_in, hd_n_in};

    sync_qual_sync2 #(
        .WIDTH   (2),
        .RST_VAL (2'b11)
    ) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (raw_n),
        .dout (syn_n)
    );

    always_comb begin
        if (std_sel) begin
            hd_lo = HD_LO_B;
            hd_hi = HD_HI_B;
        end else begin
            hd_lo = HD_LO_A;
            hd_hi = HD_HI_A;
        end
    end

    sync_qual_meas #(
        .CNT_W (CNT_W),
        .MIN_W (HD_MIN_W)
    ) u_hd_meas (
        .clk    (clk),
        .rst    (rst),
        .sig_n  (syn_n[0]),
        .lim_lo (hd_lo),
        .lim_hi (hd_hi),
        .evt    (hd_evt),
        .period (hd_period)
    );

    sync_qual_meas #(
        .CNT_W (CNT_W),
        .MIN_W (VD_MIN_W)
    ) u_vd_meas (
        .clk    (clk),
        .rst    (rst),
        .sig_n  (syn_n[1]),
        .lim_lo (VD_LO),
        .lim_hi (VD_HI),
        .evt    (vd_evt),
        .period (vd_period)
    );

    sync_qual_lock #(
        .LOCK_HD (LOCK_HD),
        .LOSS_HD (LOSS_HD),
        .LOSS_VD (LOSS_VD)
    ) u_lock (
        .clk      (clk),
        .rst      (rst),
        .hd_evt   (hd_evt),
        .vd_evt   (vd_evt),
        .ext_mode (ext_mode)
    );

    assign hd_valid = hd_evt.good;
    assign vd_valid = vd_evt.good;
endmodule

// File: rtl/sync_qual_chk.sv
module sync_qual_chk #(
    parameter int unsigned      CNT_W   = 20,
    parameter logic [CNT_W-1:0] HD_LO_A = '0,
    parameter logic [CNT_W-1:0] HD_HI_A = '1,
    parameter logic [CNT_W-1:0] HD_LO_B = '0,
    parameter logic [CNT_W-1:0] HD_HI_B = '1,
    parameter logic [CNT_W-1:0] VD_LO   = '0,
    parameter logic [CNT_W-1:0] VD_HI   = '1
) (
    input logic             clk,
    input logic             rst,
    input logic             std_sel,
    input logic             hd_valid,
    input logic [CNT_W-1:0] hd_period,
    input logic             vd_valid,
    input logic [CNT_W-1:0] vd_period,
    input logic             ext_mode
);
    a_r1_clear_after_reset: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!ext_mode && !hd_valid && !vd_valid));

    a_r4_r5_hd_in_window: assert property (@(posedge clk) disable iff (rst)
        hd_valid |-> (std_sel ? ((hd_period >= HD_LO_B) && (hd_period <= HD_HI_B))
                              : ((hd_period >= HD_LO_A) && (hd_period <= HD_HI_A))));

    a_r2_single_cycle_strobe: assert property (@(posedge clk) disable iff (rst)
        hd_valid |=> !hd_valid);

    a_r2_period_held: assert property (@(posedge clk) disable iff (rst)
        !hd_valid |-> $stable(hd_period));

    a_r6_vd_in_window: assert property (@(posedge clk) disable iff (rst)
        vd_valid |-> ((vd_period >= VD_LO) && (vd_period <= VD_HI)));

    a_r7_entry_follows_strobe: assert property (@(posedge clk) disable iff (rst)
        $rose(ext_mode) |-> ($past(hd_valid, 2) || $past(vd_valid, 2)));
endmodule

bind sync_qual sync_qual_chk #(
    .CNT_W   (CNT_W),
    .HD_LO_A (HD_LO_A),
    .HD_HI_A (HD_HI_A),
    .HD_LO_B (HD_LO_B),
    .HD_HI_B (HD_HI_B),
    .VD_LO   (VD_LO),
    .VD_HI   (VD_HI)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .std_sel   (std_sel),
    .hd_valid  (hd_valid),
    .hd_period (hd_period),
    .vd_valid  (vd_valid),
    .vd_period (vd_period),
    .ext_mode  (ext_mode)
);

// File: tb/sync_qual_bench.sv
module sync_qual_bench;
    localparam int CW  = 12;
    localparam int HA  = 100;
    localparam int HB  = 120;
    localparam int VN  = 1000;
    localparam int TD  = 100;
    localparam int HMW = 10;
    localparam int VMW = 50;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          hd_n = 1'b1;
    logic          vd_n = 1'b1;
    logic          std_sel = 1'b0;
    logic          hd_valid;
    logic [CW-1:0] hd_period;
    logic          vd_valid;
    logic [CW-1:0] vd_period;
    logic          ext_mode;

    sync_qual #(
        .CNT_W (CW), .HD_NOM_525 (HA), .HD_NOM_625 (HB), .VD_NOM (VN),
        .TOL_DIV (TD), .HD_MIN_W (HMW), .VD_MIN_W (VMW),
        .LOCK_HD (4), .LOSS_HD (8), .LOSS_VD (2)
    ) u_sync_qual (
        .clk (clk), .rst (rst), .hd_n_in (hd_n), .vd_n_in (vd_n),
        .std_sel (std_sel), .hd_valid (hd_valid), .hd_period (hd_period),
        .vd_valid (vd_valid), .vd_period (vd_period), .ext_mode (ext_mode)
    );

    always #5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        int    per;
        string tag;
    } exp_t;
    exp_t hq[$];
    exp_t vq[$];
    string hd_tag = "R2";
    string vd_tag = "R6";

    bit hd_ref = 1'b0;
    int hd_last = 0;
    bit hd_wok = 1'b0;
    bit vd_ref = 1'b0;
    int vd_last = 0;
    bit vd_wok = 1'b0;
    bit vd_on = 1'b0;
    bit vd_busy = 1'b0;
    int vd_wid = 60;
    int vd_sent = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // HD driver: pushes the strobe the requirements predict for this edge
    task automatic hd_pulse(input int per, input int wid);
        int nom;
        int gap;
        nom = std_sel ? HB : HA;
        gap = cyc - hd_last;
        if (hd_ref && hd_wok && gap >= nom - nom / TD && gap <= nom + nom / TD) begin
            exp_t e;
            e.per = gap;
            e.tag = hd_tag;
            hq.push_back(e);
        end
        hd_ref  = 1'b1;
        hd_last = cyc;
        hd_wok  = (wid >= HMW);
        hd_n = 1'b0;
        repeat (wid) @(negedge clk);
        hd_n = 1'b1;
        repeat (per - wid) @(negedge clk);
    endtask

    // VD background driver
    initial begin
        forever begin
            if (vd_on) begin
                int gap;
                int w;
                vd_busy = 1'b1;
                w   = vd_wid;
                gap = cyc - vd_last;
                if (vd_ref && vd_wok && gap >= VN - VN / TD && gap <= VN + VN / TD) begin
                    exp_t e;
                    e.per = gap;
                    e.tag = vd_tag;
                    vq.push_back(e);
                end
                vd_ref  = 1'b1;
                vd_last = cyc;
                vd_wok  = (w >= VMW);
                vd_n = 1'b0;
                repeat (w) @(negedge clk);
                vd_n = 1'b1;
                repeat (VN - w) @(negedge clk);
                vd_sent++;
                vd_busy = 1'b0;
            end else begin
                @(negedge clk);
            end
        end
    end

    // Monitor: pops and compares as strobes appear
    always @(negedge clk) begin
        if (!rst) begin
            if (hd_valid) begin
                checks++;
                if (hq.size() == 0) begin
                    errors++;
                    $display("FAIL %s: unexpected hd_valid actual=%0d expected=no strobe",
                             hd_tag, hd_period);
                end else begin
                    exp_t e;
                    e = hq.pop_front();
                    if (int'(hd_period) != e.per) begin
                        errors++;
                        $display("FAIL %s: hd_period actual=%0d expected=%0d",
                                 e.tag, hd_period, e.per);
                    end
                end
            end
            if (vd_valid) begin
                checks++;
                if (vq.size() == 0) begin
                    errors++;
                    $display("FAIL %s: unexpected vd_valid actual=%0d expected=no strobe",
                             vd_tag, vd_period);
                end else begin
                    exp_t e;
                    e = vq.pop_front();
                    if (int'(vd_period) != e.per) begin
                        errors++;
                        $display("FAIL %s: vd_period actual=%0d expected=%0d",
                                 e.tag, vd_period, e.per);
                    end
                end
            end
        end
    end

    task automatic do_reset(input bit sel);
        vd_on = 1'b0;
        wait (!vd_busy);
        repeat (20) @(negedge clk);
        chk(hq.size() == 0, "R2", "pending hd strobes", hq.size(), 0);
        chk(vq.size() == 0, "R6", "pending vd strobes", vq.size(), 0);
        rst = 1'b1;
        std_sel = sel;
        hd_ref = 1'b0;
        vd_ref = 1'b0;
        vd_wid = 60;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic do_lock();
        vd_sent = 0;
        vd_on = 1'b1;
        wait (vd_sent >= 2);
        @(negedge clk);
        repeat (5) hd_pulse(HA, 12);
        chk(ext_mode == 1'b1, "R7", "ext_mode after lock", ext_mode, 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not end actual=%0d expected=%0d", cyc, 100000);
        summary();
    end

    initial begin
        int stop_at;
        repeat (4) @(negedge clk);
        // R1 reset state
        chk(ext_mode == 1'b0, "R1", "ext_mode in reset", ext_mode, 0);
        chk(hd_valid == 1'b0 && vd_valid == 1'b0, "R1", "strobes in reset", hd_valid, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(hd_period == '0 && vd_period == '0, "R1", "periods after reset", hd_period, 0);

        // R2 / R7: HD alone gives strobes but no external mode
        hd_tag = "R2";
        repeat (6) hd_pulse(HA, 12);
        repeat (5) @(negedge clk);
        chk(ext_mode == 1'b0, "R7", "ext_mode with HD only", ext_mode, 0);

        // R4: window edges for the 525-line standard
        hd_tag = "R4";
        hd_pulse(99, 12);
        hd_pulse(101, 12);
        hd_pulse(98, 12);
        hd_pulse(100, 12);
        hd_pulse(102, 12);
        hd_pulse(100, 12);
        hd_pulse(100, 12);

        // R3: minimum low width
        hd_tag = "R3";
        hd_pulse(100, HMW - 1);
        hd_pulse(100, 12);
        hd_pulse(100, HMW);
        hd_pulse(100, 12);
        hd_pulse(100, 12);

        // R5: 625-line window
        do_reset(1'b1);
        hd_tag = "R5";
        hd_pulse(120, 12);
        hd_pulse(119, 12);
        hd_pulse(121, 12);
        hd_pulse(100, 12);
        hd_pulse(118, 12);
        hd_pulse(122, 12);
        hd_pulse(120, 12);
        hd_pulse(120, 12);

        // R6: VD width and spacing, no HD so no lock
        do_reset(1'b0);
        vd_tag = "R6";
        vd_sent = 0;
        vd_wid = VMW - 1;
        vd_on = 1'b1;
        wait (vd_sent >= 2);
        vd_wid = VMW;
        wait (vd_sent >= 4);
        vd_wid = 60;
        wait (vd_sent >= 5);
        chk(ext_mode == 1'b0, "R7", "ext_mode with VD only", ext_mode, 0);

        // R7: exact entry count
        do_reset(1'b0);
        hd_tag = "R7";
        vd_sent = 0;
        vd_on = 1'b1;
        wait (vd_sent >= 2);
        @(negedge clk);
        repeat (4) hd_pulse(HA, 12);
        chk(ext_mode == 1'b0, "R7", "ext_mode after 3 valid HD", ext_mode, 0);
        hd_pulse(HA, 12);
        chk(ext_mode == 1'b1, "R7", "ext_mode after 4 valid HD", ext_mode, 1);

        // R8: 7 faults then good keeps lock, 8 faults drop it
        hd_tag = "R8";
        repeat (7) hd_pulse(95, 12);
        repeat (2) hd_pulse(HA, 12);
        chk(ext_mode == 1'b1, "R8", "ext_mode after 7 faults", ext_mode, 1);
        repeat (8) hd_pulse(95, 12);
        hd_pulse(HA, 12);
        chk(ext_mode == 1'b0, "R8", "ext_mode after 8 faults", ext_mode, 0);

        // R8: HD train stops
        do_reset(1'b0);
        hd_tag = "R8";
        do_lock();
        repeat (600) @(negedge clk);
        chk(ext_mode == 1'b1, "R8", "ext_mode 6 windows after HD stop", ext_mode, 1);
        repeat (500) @(negedge clk);
        chk(ext_mode == 1'b0, "R8", "ext_mode 10 windows after HD stop", ext_mode, 0);
        hd_pulse(HA, 12);
        hd_pulse(HA, 12);

        // R9: VD train stops while HD runs
        do_reset(1'b0);
        hd_tag = "R9";
        do_lock();
        vd_on = 1'b0;
        @(negedge clk);
        stop_at = vd_last + 1800;
        while (cyc < stop_at) hd_pulse(HA, 12);
        chk(ext_mode == 1'b1, "R9", "ext_mode after 1 VD fault", ext_mode, 1);
        stop_at = vd_last + 2300;
        while (cyc < stop_at) hd_pulse(HA, 12);
        chk(ext_mode == 1'b0, "R9", "ext_mode after 2 VD faults", ext_mode, 0);

        do_reset(1'b0);
        summary();
    end
endmodule